// File: doc/BRIEF.md
# Linear CCD Drive Timing Generator

This block produces every digital drive clock for a three-colour staggered linear CCD sensor from one fast system clock. The outputs are three transfer-gate pulses (red, green, blue), two complementary shift clocks, a reset gate, a clamp clock and a resolution select. Each line is sequenced as a guarded transfer period followed by pixel readout. During readout every output pixel carries a region tag (invalid, optical black, valid) and a one-cycle sample strobe, so that a downstream converter can frame the line.

The resolution mode sets the framing counts and the reset cadence. Full resolution reads odd and even pixels. Half resolution reads only even pixels. Quarter resolution also reads only even pixels, and it fires the reset gate on every second pixel period so that two adjacent charges add together. The clamp mode selects either a per-pixel clamp pulse or a clamp that is simply the inverse of the transfer pulse. The mode, the transfer width and the guard width are captured only when a line begins. A line begins on a one-cycle start, or repeats back to back while free-run is held.

Top module: `ccd_drive_gen`

## Requirements
- R1: While synchronous reset is held, and in the idle state after it, all three transfer gates, phi1, the reset gate, the clamp clock, the strobe and line-done are low, the tag is 00 and phi2 is high. Reset also drives the resolution select low.
- R2: A line begins on the cycle after start (or free-run) is seen high in idle. The line starts with H cycles of phi1 high, phi2 low and the reset gate low. Next come the transfer cycles. Then come H more cycles in the same steady state before the first readout cycle. H is the larger of the hold-width input and HOLD_MIN.
- R3: The three transfer-gate outputs are high together for T cycles, where T is the transfer-width input limited to the range TG_MIN to TG_MAX.
- R4: In readout, each pixel period lasts PIX_CYC cycles. phi1 is high for the first PIX_CYC/2 cycles of the period and phi2 is its exact complement.
- R5: The reset gate is a one-cycle pulse in the first cycle of each group. A group is one pixel period in full and half resolution and two pixel periods in quarter resolution. The reset gate is low from the start of a line until readout begins.
- R6: In bit-clamp mode (clamp-mode input 0) the clamp clock is high through the guards and the transfer, and in readout it pulses for one cycle in the second cycle of each group. In line-clamp mode (input 1) the clamp clock is low during the transfer and high in the guards and throughout readout.
- R7: The resolution select is high for full resolution (mode code 0) and low for half (code 1) and quarter (code 2, and code 3, which behaves as quarter). It changes only when a line begins.
- R8: Each line holds, in order, INV leading invalid, OB black, VAL valid and INV trailing invalid output pixels. The counts come from the mode: 4/47/10800, 2/24/5400 or 1/12/2700 by default. The tag reads 00 invalid, 01 black, 10 valid, and it is 00 outside readout.
- R9: The sample strobe is a one-cycle pulse in the last cycle of each group. It therefore fires once per output pixel and never in the first period of a binned pair.
- R10: Changes to the mode, clamp mode, transfer-width or hold-width inputs during a line have no effect on that line.
- R11: Line-done is a one-cycle pulse in the cycle after the last readout cycle. If free-run is high, the next line's first guard cycle is that same cycle. Otherwise the block returns to idle.
- R12: Readout lasts exactly (2·INV+OB+VAL)·group·PIX_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to run one line |
| free_run_i | input | 1 | Keep running lines back to back |
| res_mode_i | input | 2 | 0 full, 1 half, 2/3 quarter resolution |
| clamp_line_i | input | 1 | 0 bit clamp, 1 line clamp |
| tg_len_i | input | LW | Transfer width in cycles |
| hold_len_i | input | HW | Guard width around the transfer, in cycles |
| tg_r_o | output | 1 | Red transfer gate |
| tg_g_o | output | 1 | Green transfer gate |
| tg_b_o | output | 1 | Blue transfer gate |
| phi1_o | output | 1 | Shift clock phase 1 |
| phi2_o | output | 1 | Shift clock phase 2 |
| rg_o | output | 1 | Reset gate |
| clb_o | output | 1 | Clamp clock |
| sel_o | output | 1 | Resolution select to the sensor |
| pix_tag_o | output | 2 | Region tag of the current output pixel |
| pix_strobe_o | output | 1 | Sample strobe for the converter |
| line_done_o | output | 1 | End-of-line pulse |

## Verification
The assertions watch several properties on every cycle: the reset gate stays low while the transfer gates are high, phi1 is steady and the reset gate is low on both sides of each transfer edge, the shift clocks are complementary through readout, the resolution select never moves during a transfer, and line-done lasts one cycle. Only the bench's scenarios can show the whole-line properties: the per-mode framing counts seen through strobe and tag, the limiting of the transfer and guard widths, the binned reset cadence, inputs changed mid-line being ignored, and the back-to-back handover in free-run.

// File: rtl/ccd_drive_pkg.sv
// Shared types for the CCD drive timing generator.
package ccd_drive_pkg;
    // Line sequencer state
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_TG   = 3'd2,
        ST_POST = 3'd3,
        ST_READ = 3'd4
    } line_st_t;

    // Region tag of an output pixel
    typedef enum logic [1:0] {
        TAG_INV = 2'b00,
        TAG_OB  = 2'b01,
        TAG_VAL = 2'b10
    } pix_tag_t;
endpackage

// File: rtl/ccd_region_map.sv
// Maps the output pixel index to a region tag and gives the last index of
// the line for the latched resolution mode.
// Assumes: res_q is stable for the whole line; CW holds the largest line.
module ccd_region_map
    import ccd_drive_pkg::*;
#(
    parameter int INV_HI  = 4,
    parameter int OB_HI   = 47,
    parameter int VAL_HI  = 10800,
    parameter int INV_MID = 2,
    parameter int OB_MID  = 24,
    parameter int VAL_MID = 5400,
    parameter int INV_LO  = 1,
    parameter int OB_LO   = 12,
    parameter int VAL_LO  = 2700,
    parameter int CW      = 14
) (
    input  logic [1:0]    res_q,
    input  logic          in_read,
    input  logic [CW-1:0] opix,
    output pix_tag_t      tag,
    output logic [CW-1:0] last_pix,
    output logic          bin2
);
    localparam logic [CW-1:0] HI_B1  = CW'(INV_HI);
    localparam logic [CW-1:0] HI_B2  = CW'(INV_HI + OB_HI);
    localparam logic [CW-1:0] HI_B3  = CW'(INV_HI + OB_HI + VAL_HI);
    localparam logic [CW-1:0] HI_E   = CW'(2*INV_HI + OB_HI + VAL_HI - 1);
    localparam logic [CW-1:0] MID_B1 = CW'(INV_MID);
    localparam logic [CW-1:0] MID_B2 = CW'(INV_MID + OB_MID);
    localparam logic [CW-1:0] MID_B3 = CW'(INV_MID + OB_MID + VAL_MID);
    localparam logic [CW-1:0] MID_E  = CW'(2*INV_MID + OB_MID + VAL_MID - 1);
    localparam logic [CW-1:0] LO_B1  = CW'(INV_LO);
    localparam logic [CW-1:0] LO_B2  = CW'(INV_LO + OB_LO);
    localparam logic [CW-1:0] LO_B3  = CW'(INV_LO + OB_LO + VAL_LO);
    localparam logic [CW-1:0] LO_E   = CW'(2*INV_LO + OB_LO + VAL_LO - 1);

    logic [CW-1:0] b1, b2, b3;

    // Select the region boundaries of the latched mode
    always_comb begin
        unique case (res_q)
            2'd0:    begin b1 = HI_B1;  b2 = HI_B2;  b3 = HI_B3;  last_pix = HI_E;  end
            2'd1:    begin b1 = MID_B1; b2 = MID_B2; b3 = MID_B3; last_pix = MID_E; end
            default: begin b1 = LO_B1;  b2 = LO_B2;  b3 = LO_B3;  last_pix = LO_E;  end
        endcase
    end

    assign bin2 = res_q[1];

    // Classify the current output pixel
    always_comb begin
        if (!in_read || opix < b1) tag = TAG_INV;
        else if (opix < b2)        tag = TAG_OB;
        else if (opix < b3)        tag = TAG_VAL;
        else                       tag = TAG_INV;
    end
endmodule

// File: rtl/ccd_line_seq.sv
// Line sequencer: idle, guard, transfer, guard, readout. Counts pixel phase,
// binning sub-period and output pixel, and latches the line settings.
// Assumes: PIX_CYC >= 4, HOLD_MIN >= 1, TG_MIN >= 1, LW >= HW.
module ccd_line_seq
    import ccd_drive_pkg::*;
#(
    parameter int PIX_CYC  = 8,
    parameter int PW       = 3,
    parameter int CW       = 14,
    parameter int LW       = 16,
    parameter int HW       = 12,
    parameter int TG_MIN   = 500,
    parameter int TG_MAX   = 5000,
    parameter int HOLD_MIN = 90
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          free_run,
    input  logic [1:0]    res_mode,
    input  logic          clamp_line,
    input  logic [LW-1:0] tg_len,
    input  logic [HW-1:0] hold_len,
    input  logic [CW-1:0] last_pix,
    input  logic          bin2,
    output line_st_t      st,
    output logic [PW-1:0] ph,
    output logic          grp_first,
    output logic          grp_last,
    output logic [CW-1:0] opix,
    output logic [1:0]    res_q,
    output logic          clamp_q,
    output logic          sel_q,
    output logic          line_done
);
    localparam logic [LW-1:0] TG_LO   = LW'(TG_MIN);
    localparam logic [LW-1:0] TG_HI   = LW'(TG_MAX);
    localparam logic [HW-1:0] HOLD_LO = HW'(HOLD_MIN);
    localparam logic [PW-1:0] PH_END  = PW'(PIX_CYC - 1);

    logic [LW-1:0] cnt, tg_q, tg_eff, hold_end;
    logic [HW-1:0] hold_q, hold_eff;
    logic          sub, read_end, go;

    assign tg_eff    = (tg_len < TG_LO) ? TG_LO : ((tg_len > TG_HI) ? TG_HI : tg_len);
    assign hold_eff  = (hold_len < HOLD_LO) ? HOLD_LO : hold_len;
    assign hold_end  = LW'(hold_q) - LW'(1);
    assign grp_first = !sub;
    assign grp_last  = !bin2 || sub;
    assign read_end  = (st == ST_READ) && (ph == PH_END) && grp_last && (opix == last_pix);
    assign go        = ((st == ST_IDLE) && (start || free_run)) || (read_end && free_run);

    // Capture the line settings when a line begins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= 2'd0;
            clamp_q <= 1'b0;
            sel_q   <= 1'b0;
            tg_q    <= TG_LO;
            hold_q  <= HOLD_LO;
        end else if (go) begin
            res_q   <= res_mode;
            clamp_q <= clamp_line;
            sel_q   <= (res_mode == 2'd0);
            tg_q    <= tg_eff;
            hold_q  <= hold_eff;
        end
    end

    // Walk the line phases and the readout counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            ph        <= '0;
            sub       <= 1'b0;
            opix      <= '0;
            line_done <= 1'b0;
        end else begin
            line_done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (go) st <= ST_PRE;
                end
                ST_PRE: begin
                    if (cnt == hold_end) begin st <= ST_TG; cnt <= '0; end
                    else cnt <= cnt + LW'(1);
                end
                ST_TG: begin
                    if (cnt == tg_q - LW'(1)) begin st <= ST_POST; cnt <= '0; end
                    else cnt <= cnt + LW'(1);
                end
                ST_POST: begin
                    if (cnt == hold_end) begin
                        st   <= ST_READ;
                        cnt  <= '0;
                        ph   <= '0;
                        sub  <= 1'b0;
                        opix <= '0;
                    end else cnt <= cnt + LW'(1);
                end
                ST_READ: begin
                    if (ph != PH_END) ph <= ph + PW'(1);
                    else begin
                        ph <= '0;
                        if (!grp_last) sub <= 1'b1;
                        else begin
                            sub <= 1'b0;
                            if (opix == last_pix) begin
                                line_done <= 1'b1;
                                opix      <= '0;
                                st        <= free_run ? ST_PRE : ST_IDLE;
                            end else opix <= opix + CW'(1);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R3
    tg_width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TG) |-> (tg_q >= TG_LO && tg_q <= TG_HI));
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);
    // R7
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TG) |=> $stable(sel_q));
endmodule

// File: rtl/ccd_pixel_wave.sv
// Decodes sequencer state and pixel phase into the sensor drive waveforms.
// Assumes: PIX_CYC >= 4 so reset, clamp and strobe fall in distinct cycles.
module ccd_pixel_wave
    import ccd_drive_pkg::*;
#(
    parameter int PIX_CYC = 8,
    parameter int PW      = 3
) (
    input  line_st_t      st,
    input  logic [PW-1:0] ph,
    input  logic          grp_first,
    input  logic          grp_last,
    input  logic          clamp_line,
    output logic          phi1,
    output logic          phi2,
    output logic          rg,
    output logic          clb,
    output logic          tg,
    output logic          strobe
);
    localparam logic [PW-1:0] PH_HALF = PW'(PIX_CYC / 2);
    localparam logic [PW-1:0] PH_END  = PW'(PIX_CYC - 1);

    logic guard, rd;

    assign guard = (st == ST_PRE) || (st == ST_POST);
    assign rd    = (st == ST_READ);
    assign tg    = (st == ST_TG);

    // Shift clocks: held through transfer, parked with phase 2 high in idle
    always_comb begin
        phi1 = guard || tg || (rd && ph < PH_HALF);
        phi2 = (st == ST_IDLE) || (rd && ph >= PH_HALF);
    end

    // Reset gate, clamp clock and sample strobe
    always_comb begin
        rg     = rd && (ph == '0) && grp_first;
        strobe = rd && (ph == PH_END) && grp_last;
        if (clamp_line) clb = guard || rd;
        else            clb = guard || tg || (rd && ph == PW'(1) && grp_first);
    end
endmodule

// File: rtl/ccd_drive_gen.sv
// Top of the linear CCD drive timing generator: sequencer, region map and
// waveform decoder. Outputs decode registered state directly.
// Assumes: PIX_CYC cycles of clk give a pixel rate no higher than the sensor allows.
module ccd_drive_gen
    import ccd_drive_pkg::*;
#(
    parameter int PIX_CYC  = 8,
    parameter int INV_HI   = 4,
    parameter int OB_HI    = 47,
    parameter int VAL_HI   = 10800,
    parameter int INV_MID  = 2,
    parameter int OB_MID   = 24,
    parameter int VAL_MID  = 5400,
    parameter int INV_LO   = 1,
    parameter int OB_LO    = 12,
    parameter int VAL_LO   = 2700,
    parameter int TG_MIN   = 500,
    parameter int TG_MAX   = 5000,
    parameter int HOLD_MIN = 90,
    parameter int LW       = 16,
    parameter int HW       = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          free_run_i,
    input  logic [1:0]    res_mode_i,
    input  logic          clamp_line_i,
    input  logic [LW-1:0] tg_len_i,
    input  logic [HW-1:0] hold_len_i,
    output logic          tg_r_o,
    output logic          tg_g_o,
    output logic          tg_b_o,
    output logic          phi1_o,
    output logic          phi2_o,
    output logic          rg_o,
    output logic          clb_o,
    output logic          sel_o,
    output logic [1:0]    pix_tag_o,
    output logic          pix_strobe_o,
    output logic          line_done_o
);
    localparam int PW     = (PIX_CYC > 2) ? $clog2(PIX_CYC) : 1;
    localparam int TOT_HI = 2*INV_HI + OB_HI + VAL_HI;
    localparam int TOT_MD = 2*INV_MID + OB_MID + VAL_MID;
    localparam int TOT_LO = 2*INV_LO + OB_LO + VAL_LO;
    localparam int TOT_MX = (TOT_HI > TOT_MD) ? ((TOT_HI > TOT_LO) ? TOT_HI : TOT_LO)
                                              : ((TOT_MD > TOT_LO) ? TOT_MD : TOT_LO);
    localparam int CW     = $clog2(TOT_MX + 1);

    line_st_t      st;
    logic [PW-1:0] ph;
    logic [CW-1:0] opix, last_pix;
    logic [1:0]    res_q;
    logic          grp_first, grp_last, clamp_q, bin2, tg;
    pix_tag_t      tag;

    ccd_line_seq #(
        .PIX_CYC(PIX_CYC), .PW(PW), .CW(CW), .LW(LW), .HW(HW),
        .TG_MIN(TG_MIN), .TG_MAX(TG_MAX), .HOLD_MIN(HOLD_MIN)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start_i), .free_run(free_run_i),
        .res_mode(res_mode_i), .clamp_line(clamp_line_i), .tg_len(tg_len_i),
        .hold_len(hold_len_i), .last_pix(last_pix), .bin2(bin2), .st(st), .ph(ph),
        .grp_first(grp_first), .grp_last(grp_last), .opix(opix), .res_q(res_q),
        .clamp_q(clamp_q), .sel_q(sel_o), .line_done(line_done_o)
    );

    ccd_region_map #(
        .INV_HI(INV_HI), .OB_HI(OB_HI), .VAL_HI(VAL_HI),
        .INV_MID(INV_MID), .OB_MID(OB_MID), .VAL_MID(VAL_MID),
        .INV_LO(INV_LO), .OB_LO(OB_LO), .VAL_LO(VAL_LO), .CW(CW)
    ) map_i (
        .res_q(res_q), .in_read(st == ST_READ), .opix(opix),
        .tag(tag), .last_pix(last_pix), .bin2(bin2)
    );

    ccd_pixel_wave #(.PIX_CYC(PIX_CYC), .PW(PW)) wave_i (
        .st(st), .ph(ph), .grp_first(grp_first), .grp_last(grp_last),
        .clamp_line(clamp_q), .phi1(phi1_o), .phi2(phi2_o), .rg(rg_o),
        .clb(clb_o), .tg(tg), .strobe(pix_strobe_o)
    );

    // All three colour rows transfer together
    assign tg_r_o    = tg;
    assign tg_g_o    = tg;
    assign tg_b_o    = tg;
    assign pix_tag_o = tag;

    // R5
    rg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tg_r_o |-> !rg_o);
    // R2
    tg_lead_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tg_r_o) |-> ($past(phi1_o) && !$past(phi2_o) && !$past(rg_o)));
    // R2
    tg_trail_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tg_r_o) |-> (phi1_o && !phi2_o && !rg_o));
    // R4
    phi_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ) |-> (phi1_o != phi2_o));
    // R7
    sel_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_o) |-> !tg_r_o);
endmodule

// File: tb/ccd_drive_gen_tb.sv
module ccd_drive_gen_tb_top;
    localparam int P     = 4;
    localparam int TGMIN = 4;
    localparam int TGMAX = 12;
    localparam int HMIN  = 3;

    logic        clk = 1'b0;
    logic        rst_n, start_i, free_run_i, clamp_line_i;
    logic [1:0]  res_mode_i;
    logic [15:0] tg_len_i;
    logic [11:0] hold_len_i;
    logic        tg_r_o, tg_g_o, tg_b_o, phi1_o, phi2_o, rg_o, clb_o, sel_o;
    logic [1:0]  pix_tag_o;
    logic        pix_strobe_o, line_done_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ccd_drive_gen #(
        .PIX_CYC(P), .INV_HI(2), .OB_HI(3), .VAL_HI(8),
        .INV_MID(1), .OB_MID(2), .VAL_MID(4),
        .INV_LO(1), .OB_LO(1), .VAL_LO(2),
        .TG_MIN(TGMIN), .TG_MAX(TGMAX), .HOLD_MIN(HMIN), .LW(16), .HW(12)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .free_run_i(free_run_i),
        .res_mode_i(res_mode_i), .clamp_line_i(clamp_line_i), .tg_len_i(tg_len_i),
        .hold_len_i(hold_len_i), .tg_r_o(tg_r_o), .tg_g_o(tg_g_o), .tg_b_o(tg_b_o),
        .phi1_o(phi1_o), .phi2_o(phi2_o), .rg_o(rg_o), .clb_o(clb_o), .sel_o(sel_o),
        .pix_tag_o(pix_tag_o), .pix_strobe_o(pix_strobe_o), .line_done_o(line_done_o)
    );

    task automatic chk(input string r, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    function automatic int f_inv(input int m);
        return (m == 0) ? 2 : 1;
    endfunction
    function automatic int f_ob(input int m);
        return (m == 0) ? 3 : ((m == 1) ? 2 : 1);
    endfunction
    function automatic int f_val(input int m);
        return (m == 0) ? 8 : ((m == 1) ? 4 : 2);
    endfunction
    function automatic int f_grp(input int m);
        return (m >= 2) ? 2 : 1;
    endfunction
    function automatic int f_tot(input int m);
        return 2 * f_inv(m) + f_ob(m) + f_val(m);
    endfunction
    function automatic int f_tg(input int v);
        return (v < TGMIN) ? TGMIN : ((v > TGMAX) ? TGMAX : v);
    endfunction
    function automatic int f_hold(input int v);
        return (v < HMIN) ? HMIN : v;
    endfunction

    task automatic setup(input int m, input int cm, input int tgl, input int hl);
        @(negedge clk);
        res_mode_i   = 2'(m);
        clamp_line_i = cm[0];
        tg_len_i     = 16'(tgl);
        hold_len_i   = 12'(hl);
    endtask

    task automatic start_line();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Observe one line from its first guard cycle until the line-done sample
    task automatic watch_line(input int m, input int cm, input int tgl, input int hl,
                              input bit flip);
        int em = (m == 3) ? 2 : m;
        int phase = 0, pre = 0, tgc = 0, post = 0, rd = 0, rgc = 0, rgbad = 0;
        int clbtg = 0, clbg = 0, clbrd = 0, phibad = 0, phi1rd = 0, seltg = 0;
        int si = 0, so = 0, sv = 0, tagbad = 0, tgeq = 0, cyc = 0;
        forever begin
            if (phase == 0 && tg_r_o) phase = 1;
            else if (phase == 1 && !tg_r_o) phase = 2;
            else if (phase == 2 && rg_o) phase = 3;
            case (phase)
                0, 2: begin
                    if (phase == 0) pre++; else post++;
                    if (rg_o) rgbad++;
                    if (!(phi1_o && !phi2_o)) phibad++;
                    if (!clb_o) clbg++;
                    if (pix_tag_o != 2'b00) tagbad++;
                end
                1: begin
                    tgc++;
                    if (rg_o) rgbad++;
                    if (!(phi1_o && !phi2_o)) phibad++;
                    if (clb_o != (cm == 0)) clbtg++;
                    if (!(tg_g_o && tg_b_o)) tgeq++;
                    seltg = int'(sel_o);
                end
                default: begin
                    rd++;
                    if (rg_o) rgc++;
                    if (clb_o) clbrd++;
                    if (phi1_o == phi2_o) phibad++;
                    if (phi1_o) phi1rd++;
                    if (pix_strobe_o) begin
                        if (pix_tag_o == 2'b00) si++;
                        else if (pix_tag_o == 2'b01) so++;
                        else if (pix_tag_o == 2'b10) sv++;
                    end
                end
            endcase
            if (flip && phase == 3 && rd == 3) begin
                res_mode_i   = 2'((em + 1) % 3);
                clamp_line_i = ~clamp_line_i;
                tg_len_i     = 16'd1;
                hold_len_i   = 12'd9;
            end
            @(negedge clk);
            cyc++;
            if (line_done_o) break;
            if (cyc > 5000) begin
                n_chk++; n_fail++;
                $display("FAIL R11 watchdog line not done actual=%0d expected=<5000", cyc);
                break;
            end
        end
        chk(flip ? "R10 R2 lead guard" : "R2 lead guard", pre, f_hold(hl));
        chk("R2 trail guard", post, f_hold(hl));
        chk(flip ? "R10 R3 transfer width" : "R3 transfer width", tgc, f_tg(tgl));
        chk("R3 colours together", tgeq, 0);
        chk("R2 R4 steady shift clocks", phibad, 0);
        chk("R4 phi1 high time", phi1rd, f_tot(em) * f_grp(em) * P / 2);
        chk("R5 reset quiet around transfer", rgbad, 0);
        chk("R5 reset pulses", rgc, f_tot(em));
        chk("R6 clamp in transfer", clbtg, 0);
        chk("R6 clamp in guards", clbg, 0);
        chk(flip ? "R10 R6 clamp in readout" : "R6 clamp in readout", clbrd,
            (cm == 0) ? f_tot(em) : f_tot(em) * f_grp(em) * P);
        chk("R7 select level", seltg, (em == 0) ? 1 : 0);
        chk("R8 R9 invalid strobes", si, 2 * f_inv(em));
        chk("R8 R9 black strobes", so, f_ob(em));
        chk(flip ? "R10 R8 valid strobes" : "R8 R9 valid strobes", sv, f_val(em));
        chk("R8 tag outside readout", tagbad, 0);
        chk(flip ? "R10 R12 readout length" : "R12 readout length", rd,
            f_tot(em) * f_grp(em) * P);
    endtask

    // Current sample is the line-done cycle with free-run low: idle parking
    task automatic check_park();
        chk("R1 R11 parked at line end",
            int'({tg_r_o, tg_g_o, tg_b_o, phi1_o, phi2_o, rg_o, clb_o, pix_strobe_o,
                  pix_tag_o != 2'b00}), 9'b000010000);
        @(negedge clk);
        chk("R11 done is one cycle", int'(line_done_o), 0);
        chk("R1 still parked", int'({phi1_o, phi2_o, rg_o, clb_o, tg_r_o}), 5'b01000);
    endtask

    task automatic one_line(input int m, input int cm, input int tgl, input int hl,
                            input bit flip);
        setup(m, cm, tgl, hl);
        start_line();
        watch_line(m, cm, tgl, hl, flip);
        check_park();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11 global watchdog actual=expired expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        rst_n = 1'b0; start_i = 1'b0; free_run_i = 1'b0; clamp_line_i = 1'b0;
        res_mode_i = 2'd0; tg_len_i = 16'd6; hold_len_i = 12'd4;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs",
            int'({tg_r_o, tg_g_o, tg_b_o, phi1_o, phi2_o, rg_o, clb_o, sel_o,
                  pix_strobe_o, line_done_o}), 10'b0000100000);
        chk("R1 reset tag", int'(pix_tag_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", int'({phi1_o, phi2_o, rg_o, clb_o, tg_r_o, sel_o}),
            6'b010000);

        // Every mode in both clamp modes
        for (int m = 0; m < 3; m++)
            for (int cm = 0; cm < 2; cm++)
                one_line(m, cm, 6, 4, 1'b0);

        // R3 width limits and R2 guard minimum
        one_line(0, 0, 0, 0, 1'b0);
        one_line(1, 1, 200, 2, 1'b0);
        one_line(3, 1, 12, 3, 1'b0);

        // R10 inputs changed mid-line, then R7 new select on the next line
        one_line(2, 0, 8, 5, 1'b1);
        one_line(0, 1, 5, 3, 1'b0);

        // R11 free-run: two lines back to back, then idle
        setup(1, 0, 7, 3);
        free_run_i = 1'b1;
        @(negedge clk);
        watch_line(1, 0, 7, 3, 1'b0);
        chk("R11 free-run next line begins", int'({phi1_o, phi2_o, rg_o}), 3'b100);
        free_run_i = 1'b0;
        watch_line(1, 0, 7, 3, 1'b0);
        check_park();

        // Random lines
        for (int i = 0; i < 12; i++) begin
            int m   = int'($urandom % 4);
            int cm  = int'($urandom % 2);
            int tgl = int'($urandom % 20);
            int hl  = int'($urandom % 7);
            one_line(m, cm, tgl, hl, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule